// File: doc/BRIEF.md
# Four-Phase Data Clock Alignment Channel

This block takes one detector bit that has already been sampled on four phases of the system clock, a quarter period apart, and turns it into a clean bit stream in the system clock domain. Each hit lasts one clock period, and its phase against the clock is not known in advance. The block watches where the data transitions fall among the four phase samples. It points its sampling tap at the phase two quarter periods away from that transition, which is the point of widest margin. The chosen sample is then registered on the system clock.

One instance serves one detector bit, so a 32-bit detector uses 32 copies. Jitter on the transition position does not move the tap, because the tap moves only after a run of edges that all fall in one phase bin. When a tap move crosses the clock boundary, the block keeps the bit sequence whole. It either reads the sample from an older clock cycle taken from a short history, or it holds the output for one cycle and flags a slip.

Top module: `phase_align_chan`

## Requirements
- R1: Phase 0 (`samp_i[0]`) is compared against phase 3 (`samp_i[3]`) of the previous clock, and phase k against phase k-1 of the same clock. The edge bin of a clock is the lowest phase index with a mismatch. A clock with no mismatch has no edge. After reset, the previous phase-3 sample counts as 0.
- R2: After reset, `sel_o` is 0 and `lock_o`, `data_o` and `slip_o` are all 0. While `lock_o` is low, `sel_o` stays 0.
- R3: A phase update fires only when LOCK_RUN (default 4) consecutive edge clocks share one bin. Clocks with no edge neither extend nor break a run. An edge in a different bin restarts the run at one. A saturated run does not fire again.
- R4: An update sets `sel_o` to (bin + 2) mod 4, visible one clock after the samples that completed the run.
- R5: `lock_o` rises with the first applied update and stays high until reset.
- R6: `data_o` is the sample at phase `sel_o` taken from the clock that is the history delay back (delay 0 means the current samples). It is registered, so it appears one clock after those samples. The history delay starts at 0.
- R7: A move from phase 3 to phase 0 while the history delay is 0 holds `data_o` at its previous value for one clock and raises `slip_o` for exactly that clock.
- R8: A move from phase 0 to phase 3 increases the history delay by one, raises no slip and loses no bit.
- R9: A move from phase 3 to phase 0 while the history delay is above 0 decreases the delay by one and raises no slip.
- R10: A move from phase 0 to phase 3 while the history delay is already HIST_DEPTH-1 (default 2) is rejected. `sel_o` and `lock_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_i | input | 4 | Samples of this clock: bit k taken at k quarter periods |
| data_o | output | 1 | Recovered bit, synchronous to clk |
| slip_o | output | 1 | High for the one clock in which data_o is a held repeat |
| lock_o | output | 1 | High once a phase has been chosen |
| sel_o | output | 2 | Phase currently used for sampling |

## Verification
The embedded properties check, every cycle, the local rules:
- a phase-0 mismatch against the previous phase-3 sample is always seen as a bin-0 edge;
- the run counter stays in range, and an update fires only on a completed run;
- the history delay never exceeds its bound;
- a slip repeats the previous bit, lasts one clock and comes only with a 3-to-0 move;
- the lock flag is sticky.

Only the bench scenarios can show the following:
- that the tap settles opposite the real transition phase;
- that jittered streams leave the choice alone;
- that the wrap moves in both directions hand over the stream without a lost or doubled bit;
- that an over-deep move is refused.

// File: rtl/pa_pkg.sv
`timescale 1ns/1ps
package pa_pkg;
    localparam int NPH  = 4;
    localparam int SELW = $clog2(NPH);

    typedef logic [NPH-1:0]  phvec_t;
    typedef logic [SELW-1:0] phsel_t;

    function automatic int dly_bits(input int depth);
        return (depth > 2) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/pa_edge_finder.sv
`timescale 1ns/1ps
module pa_edge_finder
    import pa_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phvec_t samp_i,
    output logic   any_o,
    output phsel_t bin_o
);
    typedef struct packed {
        logic last;
    } ef_state_t;

    ef_state_t st_q, st_d;
    phvec_t    edg;

    assign edg[0] = samp_i[0] ^ st_q.last;
    for (genvar k = 1; k < NPH; k++) begin : g_edge
        assign edg[k] = samp_i[k] ^ samp_i[k-1];
    end

    always_comb begin
        st_d      = st_q;
        st_d.last = samp_i[NPH-1];
        any_o     = |edg;
        bin_o     = '0;
        for (int k = NPH - 1; k >= 0; k--) begin
            if (edg[k]) bin_o = phsel_t'(k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    wrap_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_i[0] != $past(samp_i[NPH-1])) |-> (any_o && bin_o == '0));
endmodule

// File: rtl/pa_run_tracker.sv
`timescale 1ns/1ps
module pa_run_tracker
    import pa_pkg::*;
#(
    parameter int LOCK_RUN = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   any_i,
    input  phsel_t bin_i,
    output logic   fire_o,
    output phsel_t target_o
);
    localparam int                CNT_W   = $clog2(LOCK_RUN + 1);
    localparam logic [CNT_W-1:0]  RUN_MAX = CNT_W'(LOCK_RUN);
    localparam phsel_t            HALF    = phsel_t'(NPH / 2);

    typedef struct packed {
        phsel_t           last_bin;
        logic [CNT_W-1:0] cnt;
    } rt_state_t;

    rt_state_t st_q, st_d;
    logic      match;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        match  = (bin_i == st_q.last_bin) && (st_q.cnt != '0);
        if (any_i) begin
            if (!match)                 st_d.cnt = CNT_W'(1);
            else if (st_q.cnt != RUN_MAX) st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.last_bin = bin_i;
            fire_o = (st_d.cnt == RUN_MAX) && !(match && st_q.cnt == RUN_MAX);
        end
        target_o = st_d.last_bin + HALF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= RUN_MAX);

    // R3
    fire_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && LOCK_RUN > 1) |->
            (any_i && st_q.last_bin == bin_i && st_q.cnt == RUN_MAX - CNT_W'(1)));
endmodule

// File: rtl/pa_phase_switch.sv
`timescale 1ns/1ps
module pa_phase_switch
    import pa_pkg::*;
#(
    parameter  int HIST_DEPTH = 3,
    localparam int DLY_W      = dly_bits(HIST_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  phsel_t           target_i,
    output phsel_t           sel_nx_o,
    output logic [DLY_W-1:0] dly_nx_o,
    output logic             hold_o,
    output phsel_t           sel_o,
    output logic             lock_o
);
    localparam logic [DLY_W-1:0] DLY_MAX  = DLY_W'(HIST_DEPTH - 1);
    localparam phsel_t           SEL_LAST = phsel_t'(NPH - 1);

    typedef struct packed {
        phsel_t           sel;
        logic [DLY_W-1:0] dly;
        logic             lock;
    } ps_state_t;

    ps_state_t st_q, st_d;
    logic      go_later, go_earlier;

    always_comb begin
        st_d       = st_q;
        hold_o     = 1'b0;
        go_later   = (target_i == SEL_LAST) && (st_q.sel == '0);
        go_earlier = (target_i == '0) && (st_q.sel == SEL_LAST);
        if (fire_i) begin
            if (go_later) begin
                if (st_q.dly != DLY_MAX) begin
                    st_d.dly  = st_q.dly + DLY_W'(1);
                    st_d.sel  = target_i;
                    st_d.lock = 1'b1;
                end
            end else if (go_earlier) begin
                if (st_q.dly != '0) st_d.dly = st_q.dly - DLY_W'(1);
                else                hold_o   = 1'b1;
                st_d.sel  = target_i;
                st_d.lock = 1'b1;
            end else begin
                st_d.sel  = target_i;
                st_d.lock = 1'b1;
            end
        end
        sel_nx_o = st_d.sel;
        dly_nx_o = st_d.dly;
        sel_o    = st_q.sel;
        lock_o   = st_q.lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    dly_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dly <= DLY_MAX);

    // R8
    later_grows_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == SEL_LAST && $past(st_q.sel) == '0) |->
            (st_q.dly == $past(st_q.dly) + DLY_W'(1)));
endmodule

// File: rtl/pa_sample_tap.sv
`timescale 1ns/1ps
module pa_sample_tap
    import pa_pkg::*;
#(
    parameter  int HIST_DEPTH = 3,
    localparam int DLY_W      = dly_bits(HIST_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phvec_t           samp_i,
    input  phsel_t           sel_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             hold_i,
    output logic             data_o,
    output logic             slip_o
);
    localparam int DEPTH_M1 = HIST_DEPTH - 1;

    typedef struct packed {
        logic [DEPTH_M1-1:0][NPH-1:0] hist;
        logic                         data;
        logic                         slip;
    } tap_state_t;

    tap_state_t st_q, st_d;
    logic       pick;

    always_comb begin
        st_d         = st_q;
        st_d.hist[0] = samp_i;
        for (int k = 1; k < DEPTH_M1; k++) st_d.hist[k] = st_q.hist[k-1];
        pick = samp_i[sel_i];
        for (int k = 1; k <= DEPTH_M1; k++) begin
            if (dly_i == DLY_W'(k)) pick = st_q.hist[k-1][sel_i];
        end
        st_d.data = hold_i ? st_q.data : pick;
        st_d.slip = hold_i;
        data_o    = st_q.data;
        slip_o    = st_q.slip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    hold_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |-> (data_o == $past(data_o)));

    // R6
    tap_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hold_i && dly_i == '0) |-> (data_o == $past(samp_i[sel_i])));
endmodule

// File: rtl/phase_align_chan.sv
`timescale 1ns/1ps
module phase_align_chan
    import pa_pkg::*;
#(
    parameter int LOCK_RUN   = 4,
    parameter int HIST_DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] samp_i,
    output logic       data_o,
    output logic       slip_o,
    output logic       lock_o,
    output logic [1:0] sel_o
);
    localparam int     DLY_W    = dly_bits(HIST_DEPTH);
    localparam phsel_t SEL_LAST = phsel_t'(NPH - 1);

    logic             any_w, fire_w, hold_w;
    phsel_t           bin_w, target_w, sel_nx_w, sel_w;
    logic [DLY_W-1:0] dly_nx_w;

    pa_edge_finder u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp_i (samp_i),
        .any_o  (any_w),
        .bin_o  (bin_w)
    );

    pa_run_tracker #(.LOCK_RUN(LOCK_RUN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_i    (any_w),
        .bin_i    (bin_w),
        .fire_o   (fire_w),
        .target_o (target_w)
    );

    pa_phase_switch #(.HIST_DEPTH(HIST_DEPTH)) u_switch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire_w),
        .target_i (target_w),
        .sel_nx_o (sel_nx_w),
        .dly_nx_o (dly_nx_w),
        .hold_o   (hold_w),
        .sel_o    (sel_w),
        .lock_o   (lock_o)
    );

    pa_sample_tap #(.HIST_DEPTH(HIST_DEPTH)) u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp_i (samp_i),
        .sel_i  (sel_nx_w),
        .dly_i  (dly_nx_w),
        .hold_i (hold_w),
        .data_o (data_o),
        .slip_o (slip_o)
    );

    assign sel_o = sel_w;

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    // R2
    unlocked_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |-> (sel_o == '0));

    // R7
    slip_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |-> (sel_o == '0 && $past(sel_o) == SEL_LAST));

    // R7
    slip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip_o |=> !slip_o);
endmodule

// File: tb/sim_phase_align_chan.sv
`timescale 1ns/1ps
module sim_phase_align_chan;
    localparam int RUN = 4;
    localparam int DMAX = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] samp_i = '0;
    logic       data_o, slip_o, lock_o;
    logic [1:0] sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic cur  = 1'b0;

    // reference state
    logic       m_last, m_data, m_slip, m_lock;
    int         m_lastbin, m_cnt, m_sel, m_dly;
    logic [3:0] m_hist0, m_hist1;

    always #4 clk = ~clk;

    phase_align_chan u0 (
        .clk(clk), .rst_n(rst_n), .samp_i(samp_i),
        .data_o(data_o), .slip_o(slip_o), .lock_o(lock_o), .sel_o(sel_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_last = 0; m_data = 0; m_slip = 0; m_lock = 0;
        m_lastbin = 0; m_cnt = 0; m_sel = 0; m_dly = 0;
        m_hist0 = '0; m_hist1 = '0;
    endtask

    task automatic model_step(input logic [3:0] v);
        logic [3:0] e;
        int bin, old, tgt;
        bit match, fire, hold;
        logic pick;
        e[0] = v[0] ^ m_last;
        for (int k = 1; k < 4; k++) e[k] = v[k] ^ v[k-1];
        bin = 0;
        for (int k = 3; k >= 0; k--) if (e[k]) bin = k;
        fire = 0; hold = 0; old = m_cnt;
        if (e != 0) begin
            match = (bin == m_lastbin) && (m_cnt != 0);
            if (!match) m_cnt = 1;
            else if (m_cnt < RUN) m_cnt++;
            m_lastbin = bin;
            fire = (m_cnt == RUN) && !(match && old == RUN);
        end
        tgt = (m_lastbin + 2) % 4;
        if (fire) begin
            if (tgt == 3 && m_sel == 0) begin
                if (m_dly < DMAX) begin m_dly++; m_sel = 3; m_lock = 1; end
            end else if (tgt == 0 && m_sel == 3) begin
                if (m_dly > 0) m_dly--; else hold = 1;
                m_sel = 0; m_lock = 1;
            end else begin
                m_sel = tgt; m_lock = 1;
            end
        end
        pick = (m_dly == 0) ? v[m_sel] : (m_dly == 1) ? m_hist0[m_sel] : m_hist1[m_sel];
        if (!hold) m_data = pick;
        m_slip = hold;
        m_hist1 = m_hist0; m_hist0 = v; m_last = v[3];
    endtask

    // compare against the model, then apply the next sample vector
    task automatic step(input logic [3:0] v);
        @(negedge clk);
        chk(data_o === m_data, "R6 data", data_o, m_data);
        chk(slip_o === m_slip, "R7 slip", slip_o, m_slip);
        chk(lock_o === m_lock, "R5 lock", lock_o, m_lock);
        chk(int'(sel_o) == m_sel, "R4 sel", sel_o, m_sel);
        samp_i = v;
        model_step(v);
    endtask

    task automatic edges(input int b, input int n);
        for (int i = 0; i < n; i++) begin
            logic [3:0] v;
            for (int j = 0; j < 4; j++) v[j] = (j >= b) ? ~cur : cur;
            cur = ~cur;
            step(v);
        end
    endtask

    task automatic settle();
        step({4{cur}});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; samp_i = '0; cur = 0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic d0;
        void'($urandom(32'h1f2e3d4c));
        do_reset();
        @(negedge clk);
        chk(sel_o == 2'd0 && lock_o == 0, "R2 reset sel/lock", {lock_o, sel_o}, 0);
        chk(data_o == 0 && slip_o == 0, "R2 reset data/slip", {data_o, slip_o}, 0);

        // R1: phase-0 edges against previous phase 3
        edges(0, 4); settle();
        chk(int'(sel_o) == 2 && lock_o, "R1 bin0 picks phase 2", sel_o, 2);

        do_reset();
        // R3: short run, restart on another bin
        edges(1, 3); settle();
        chk(lock_o == 0 && sel_o == 0, "R3 three edges no update", {lock_o, sel_o}, 0);
        edges(2, 1); edges(1, 1); settle();
        chk(lock_o == 0, "R3 run restarted", lock_o, 0);
        edges(1, 3); settle();
        chk(int'(sel_o) == 3, "R8 later wrap applied", sel_o, 3);
        chk(slip_o == 0, "R8 no slip", slip_o, 0);
        chk(lock_o == 1, "R5 lock after first update", lock_o, 1);
        edges(2, 4); settle();
        chk(int'(sel_o) == 0 && slip_o == 0, "R9 earlier wrap with delay", {slip_o, sel_o}, 0);
        edges(1, 4); edges(0, 4); edges(3, 4); edges(2, 4);
        edges(1, 4); settle();
        chk(int'(sel_o) == 3, "R8 second later wrap", sel_o, 3);
        edges(0, 4); edges(3, 4); edges(2, 4); settle();
        chk(int'(sel_o) == 0, "R10 back at phase 0", sel_o, 0);
        edges(1, 4); settle();
        chk(int'(sel_o) == 0 && lock_o, "R10 deep move rejected", sel_o, 0);

        do_reset();
        // R7: 3 -> 0 with no history delay
        edges(3, 4); edges(0, 4); edges(1, 4); settle();
        chk(int'(sel_o) == 3, "R7 reached phase 3", sel_o, 3);
        edges(2, 3); edges(2, 1);
        d0 = data_o;
        settle();
        chk(slip_o == 1, "R7 slip raised", slip_o, 1);
        chk(data_o == d0, "R7 data held", data_o, d0);
        settle();
        chk(slip_o == 0, "R7 slip one cycle", slip_o, 0);

        // random streams with jitter around a fixed phase
        for (int seg = 0; seg < 8; seg++) begin
            int phi;
            logic bp, bc;
            do_reset();
            phi = $urandom % 4;
            bp = 0;
            for (int n = 0; n < 400; n++) begin
                int pe;
                logic [3:0] v;
                bc = 1'($urandom % 2);
                pe = phi;
                if ($urandom % 8 == 0) pe = phi + (($urandom % 2) ? 1 : -1);
                if (pe < 0) pe = 0;
                if (pe > 3) pe = 3;
                for (int j = 0; j < 4; j++) v[j] = (j >= pe) ? bc : bp;
                step(v);
                bp = bc;
            end
            settle();
            chk(lock_o == 1, "R5 locked on random stream", lock_o, 1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule